// File: doc/BRIEF.md
# Brightness Fade Ramp Engine

This block moves a 7-bit LED current code toward a requested level one code at a time, so that a lighting group brightens and dims smoothly instead of jumping. The wait between single-code steps comes from a free-standing prescaler, a rate field and a law multiplier. Separate rate fields apply to rising and to falling moves. A change from code 0 to full scale is the slowest move, and a small change finishes sooner because the number of steps equals the code distance.

While enabled, the block heads for the requested target. When disabled, it heads for zero. In fast-update mode the rate fields only shape the ramps caused by enabling or disabling. Once the fade-in has completed, a new target is loaded on the next edge. A level flag reports a completed fade-in. A single-cycle pulse reports that a fade-out reached zero, and can feed an interrupt.

Top module: `fade_ramp`

## Requirements
- R1: After reset, code_o is 0 and both fi_done_o and fo_done_o are 0.
- R2: With a nonzero rate r selected and the square law, code_o moves one code toward the goal every r*PRESC clock cycles. The first step comes r*PRESC cycles after the move begins, so a move of d codes lasts d*r*PRESC cycles.
- R3: rate_in_i sets the step interval when the goal is above code_o, and rate_out_i sets it when the goal is below code_o.
- R4: A selected rate of 0 loads the goal into code_o on the next clock edge.
- R5: law_i scales the interval by a multiplier taken from code_o[6:5]. Encoding 2'b10 uses the multipliers 4,3,2,1 for bands 0..3. Encoding 2'b11 uses 8,4,2,1. Encodings 2'b00 and 2'b01 use 1 in every band.
- R6: With fast_i low, a target change after the fade-in has completed is ramped and is not loaded at once.
- R7: With fast_i high, fi_done_o high and en_i high, code_o equals the target on the next edge. Enabling and disabling still ramp at the selected rates.
- R8: fi_done_o rises on the edge where code_o reaches target_i while en_i is high. It stays high until an edge sees en_i low.
- R9: fo_done_o is high for exactly one cycle. That cycle is the first one in which code_o reads 0 after a move from a nonzero code with en_i low.
- R10: A target change in the middle of a ramp continues from the present code without a jump, and the wait already elapsed carries over.
- R11: When en_i is low, the goal is code 0, whatever target_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Group enable; low ramps toward zero |
| fast_i | input | 1 | Fast-update mode select |
| target_i | input | 7 | Requested current code |
| rate_in_i | input | 4 | Rate field for rising moves, 0 = immediate |
| rate_out_i | input | 4 | Rate field for falling moves, 0 = immediate |
| law_i | input | 2 | Fade law select |
| code_o | output | 7 | Present current code |
| fi_done_o | output | 1 | Fade-in complete flag |
| fo_done_o | output | 1 | Single-cycle fade-out done pulse |

## Verification
A wrong prescaler phase or a wrong step counter shows on code_o as a step that comes too early or too late. The error appears at the first step of a ramp, at most r*multiplier*PRESC cycles after the move begins. A wrong law band or a wrong direction choice shows once code_o crosses a band boundary, or as soon as a falling move starts. The bench compares code_o and both flags with its own model on every cycle. Any divergence is therefore reported in the cycle it first reaches the ports. A stale fade-in flag shows in fast-update mode as a target change that is loaded when it should be ramped, or ramped when it should be loaded.

// File: rtl/fade_pkg.sv
package fade_pkg;
  typedef enum logic [1:0] {
    LAW_SQUARE   = 2'b00,
    LAW_SQUARE_B = 2'b01,
    LAW_CUBIC_A  = 2'b10,
    LAW_CUBIC_B  = 2'b11
  } fade_law_e;

  localparam int unsigned MULT_W = 4;

  // multiplier per code band, band 3 is near full scale
  function automatic logic [MULT_W-1:0] law_mult(fade_law_e law, logic [1:0] band);
    logic [MULT_W-1:0] m;
    case (law)
      LAW_CUBIC_A: m = MULT_W'(4) - MULT_W'(band);
      LAW_CUBIC_B: m = MULT_W'(8) >> band;
      default:     m = MULT_W'(1);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/fade_prescaler.sv
module fade_prescaler #(
  parameter int unsigned PRESC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/fade_interval.sv
module fade_interval
  import fade_pkg::*;
#(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned RATE_W = 4,
  localparam int unsigned IV_W  = RATE_W + MULT_W
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [1:0]        law_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [IV_W-1:0]   interval_o
);
  logic [MULT_W-1:0] mult;

  assign mult       = law_mult(fade_law_e'(law_i), code_i[CODE_W-1 -: 2]);
  assign interval_o = IV_W'(rate_i) * IV_W'(mult);
endmodule

// File: rtl/fade_stepper.sv
module fade_stepper #(
  parameter int unsigned IV_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic [IV_W-1:0] interval_i,
  output logic            step_o
);
  logic [IV_W-1:0] ticks_q;
  logic [IV_W:0]   ticks_inc;

  assign ticks_inc = {1'b0, ticks_q} + (IV_W+1)'(1);
  // >= keeps a shrinking interval (band change, retarget) from stalling
  assign step_o    = run_i && tick_i && (ticks_inc >= {1'b0, interval_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ticks_q <= '0;
    else if (!run_i)  ticks_q <= '0;
    else if (step_o)  ticks_q <= '0;
    else if (tick_i)  ticks_q <= ticks_inc[IV_W-1:0];
  end
endmodule

// File: rtl/fade_ramp.sv
module fade_ramp
  import fade_pkg::*;
#(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned RATE_W = 4,
  parameter int unsigned PRESC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fast_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic [RATE_W-1:0] rate_in_i,
  input  logic [RATE_W-1:0] rate_out_i,
  input  logic [1:0]        law_i,
  output logic [CODE_W-1:0] code_o,
  output logic              fi_done_o,
  output logic              fo_done_o
);
  localparam int unsigned IV_W = RATE_W + MULT_W;

  logic [CODE_W-1:0] cur_q, cur_d, goal;
  logic              fi_q, fo_q;
  logic              fast_apply, rising, immediate, moving;
  logic [RATE_W-1:0] rate_sel;
  logic              tick, step;
  logic [IV_W-1:0]   interval;

  assign goal       = en_i ? target_i : '0;
  assign fast_apply = fast_i && fi_q && en_i;
  assign rising     = goal > cur_q;
  assign rate_sel   = rising ? rate_in_i : rate_out_i;
  assign immediate  = fast_apply || (rate_sel == '0);
  assign moving     = (goal != cur_q) && !immediate;

  fade_prescaler #(.PRESC(PRESC)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (moving),
    .tick_o(tick)
  );

  fade_interval #(.CODE_W(CODE_W), .RATE_W(RATE_W)) u_ival (
    .rate_i    (rate_sel),
    .law_i     (law_i),
    .code_i    (cur_q),
    .interval_o(interval)
  );

  fade_stepper #(.IV_W(IV_W)) u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (moving),
    .tick_i    (tick),
    .interval_i(interval),
    .step_o    (step)
  );

  always_comb begin
    cur_d = cur_q;
    if (goal != cur_q) begin
      if (immediate)   cur_d = goal;
      else if (step)   cur_d = rising ? cur_q + CODE_W'(1) : cur_q - CODE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      fi_q  <= 1'b0;
      fo_q  <= 1'b0;
    end else begin
      cur_q <= cur_d;
      fi_q  <= en_i && (fi_q || (cur_d == target_i));
      fo_q  <= !en_i && (cur_q != '0) && (cur_d == '0);
    end
  end

  assign code_o    = cur_q;
  assign fi_done_o = fi_q;
  assign fo_done_o = fo_q;
endmodule

// File: rtl/fade_ramp_checker.sv
module fade_ramp_checker #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned RATE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              fast_i,
  input logic [CODE_W-1:0] target_i,
  input logic [RATE_W-1:0] rate_in_i,
  input logic [RATE_W-1:0] rate_out_i,
  input logic [CODE_W-1:0] code_o,
  input logic              fi_done_o,
  input logic              fo_done_o
);
  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_in_i != '0 && rate_out_i != '0 && !fast_i) |=>
      (code_o == $past(code_o) || code_o == $past(code_o) + CODE_W'(1) ||
       $past(code_o) == code_o + CODE_W'(1)));

  assert_zero_rate_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_in_i == '0 && rate_out_i == '0) |=>
      (code_o == $past(en_i ? target_i : CODE_W'(0))));

  assert_fast_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_i && fi_done_o && en_i) |=> (code_o == $past(target_i)));

  assert_rise_bounded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o > $past(code_o)) |-> ($past(en_i) && code_o <= $past(target_i)));

  assert_fi_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fi_done_o);

  assert_fo_at_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fo_done_o |-> (code_o == '0 && !$past(en_i)));

  assert_fo_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fo_done_o |=> !fo_done_o);
endmodule

bind fade_ramp fade_ramp_checker #(.CODE_W(CODE_W), .RATE_W(RATE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .fast_i    (fast_i),
  .target_i  (target_i),
  .rate_in_i (rate_in_i),
  .rate_out_i(rate_out_i),
  .code_o    (code_o),
  .fi_done_o (fi_done_o),
  .fo_done_o (fo_done_o)
);

// File: tb/fade_ramp_tb.sv
`timescale 1ns/1ps
module fade_ramp_tb;
  localparam int PRESC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, fast = 1'b0;
  logic [6:0] tgt = '0;
  logic [3:0] rin = '0, rout = '0;
  logic [1:0] law = '0;
  logic [6:0] code;
  logic       fi, fo;

  int checks = 0, errors = 0;
  bit finished = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  fade_ramp #(.PRESC(PRESC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fast_i(fast), .target_i(tgt),
    .rate_in_i(rin), .rate_out_i(rout), .law_i(law),
    .code_o(code), .fi_done_o(fi), .fo_done_o(fo)
  );

  // reference model: elapsed cycles since the last step
  int m_code = 0, m_wait = 0;
  bit m_fi = 0, m_fo = 0;

  function automatic int mult_of(int lw, int c);
    int band = c / 32;
    if (lw == 2) return 4 - band;
    if (lw == 3) return 8 / (1 << band);
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_wait = 0; m_fi = 0; m_fo = 0;
    end else begin
      int goal, rs, nxt, iv;
      bit fa, up;
      goal = en ? int'(tgt) : 0;
      fa   = fast && m_fi && en;
      up   = goal > m_code;
      rs   = up ? int'(rin) : int'(rout);
      nxt  = m_code;
      if (goal == m_code) m_wait = 0;
      else if (fa || rs == 0) begin nxt = goal; m_wait = 0; end
      else begin
        m_wait++;
        iv = rs * mult_of(int'(law), m_code);
        if (m_wait % PRESC == 0 && m_wait / PRESC >= iv) begin
          nxt = up ? m_code + 1 : m_code - 1;
          m_wait = 0;
        end
      end
      m_fo = !en && m_code != 0 && nxt == 0;
      m_fi = en && (m_fi || nxt == int'(tgt));
      m_code = nxt;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk({phase, " code"}, int'(code), m_code);
    chk({phase, " fi"}, int'(fi), int'(m_fi));
    chk({phase, " fo"}, int'(fo), int'(m_fo));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 code", int'(code), 0);
    chk("R1 fi", int'(fi), 0);
    chk("R1 fo", int'(fo), 0);

    // R2 square ramp up 0->10 at rate 2: 8 cycles per step
    phase = "R2"; rin = 2; rout = 1; law = 0; tgt = 10; en = 1;
    cyc(79); chk("R2 code before last step", int'(code), 9);
    cyc(1);  chk("R2 code at target", int'(code), 10);
    chk("R8 fi set on arrival", int'(fi), 1);

    // R3/R11 fade out at rate 1: 4 cycles per step, target ignored
    phase = "R3"; en = 0;
    cyc(1);  chk("R8 fi cleared", int'(fi), 0);
    cyc(38); chk("R3 code before zero", int'(code), 1);
    chk("R9 no early pulse", int'(fo), 0);
    cyc(1);  chk("R11 code zero", int'(code), 0);
    chk("R9 pulse", int'(fo), 1);
    cyc(1);  chk("R9 pulse one cycle", int'(fo), 0);

    // R4 zero rate loads at once
    phase = "R4"; rin = 0; rout = 0; tgt = 50; en = 1;
    cyc(1); chk("R4 immediate up", int'(code), 50);
    en = 0;
    cyc(1); chk("R4 immediate down", int'(code), 0);
    chk("R9 pulse after immediate", int'(fo), 1);

    // R5 cubic B: band 0 multiplier 8 -> 32 cycles for the first step
    phase = "R5"; law = 3; rin = 1; tgt = 40; en = 1;
    cyc(31); chk("R5 cubic B before step", int'(code), 0);
    cyc(1);  chk("R5 cubic B first step", int'(code), 1);
    cyc(1200);
    chk("R5 reached", int'(code), 40);
    law = 2; rout = 1; en = 0;
    cyc(650);
    chk("R5 cubic A down", int'(code), 0);

    // R10 retarget mid ramp
    phase = "R10"; law = 0; rin = 3; tgt = 20; en = 1;
    cyc(50);
    chk("R10 mid ramp", int'(code), 4);
    tgt = 5;
    cyc(1);  chk("R10 no jump", int'(code), 4);
    cyc(100);
    chk("R10 settled", int'(code), 5);

    // R6 non-fast: change after completion is ramped
    phase = "R6"; rin = 1; tgt = 30;
    cyc(1); chk("R6 not loaded", int'(code), 5);
    cyc(130);
    chk("R6 ramped", int'(code), 30);

    // R7 fast update
    phase = "R7"; rout = 0; en = 0;
    cyc(2);
    fast = 1; rin = 1; rout = 1; tgt = 20; en = 1;
    cyc(1);  chk("R7 enable ramps", int'(code), 0);
    cyc(84);
    chk("R7 fade-in done", int'(fi), 1);
    tgt = 90;
    cyc(1);  chk("R7 loaded next cycle", int'(code), 90);
    en = 0;
    cyc(1);  chk("R7 disable ramps", int'(code), 90);
    cyc(3);  chk("R7 first fall step", int'(code), 89);
    cyc(400);
    chk("R7 faded out", int'(code), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule